// File: doc/BRIEF.md
# In-Group Store-to-Load Overlap Detector

This block watches the memory stores issued inside one dispatch group. It raises a hazard bit when a load presented in the same group could read bytes that one of those stores writes. The issue logic uses that bit to end the group early, or to place a filler slot, before the load goes out. Each access is described by two address operands, an offset operand and a base operand, plus a two-bit size code. An operand is a 16-bit tag with a flag that marks the tag as a constant offset. The block never forms effective addresses and never reasons about pointer aliasing.

Stores are kept in a small table that fills in issue order. A pulse on the group-end input empties the table. The hazard output is combinational from the load inputs and the registered table. It flags three cases: the operand pair matches a recorded store exactly, the pair matches with the two operands swapped, or the bases are equal and both offsets are constants whose byte ranges intersect.

Top module: `st_ld_overlap_det`

## Requirements
- R1: A valid load whose offset operand and base operand each equal (flag and value) those of a recorded store gives ld_hazard = 1.
- R2: A valid load whose offset operand equals a recorded store's base operand, and whose base operand equals that store's offset operand, gives ld_hazard = 1.
- R3: When the base operands are equal, both offset operands carry the constant flag, and the store offset is below the load offset, the load is a hazard exactly when store offset + store bytes > load offset.
- R4: Under the same base and constant conditions with the store offset at or above the load offset, the load is a hazard exactly when load offset + load bytes > store offset.
- R5: Size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and 3 means 8 bytes. The codes apply to both stores and loads.
- R6: ld_hazard is 0 whenever ld_valid is 0, and whenever no store has been recorded in the current group.
- R7: A store presented with st_valid is recorded at the clock edge. A load in that same cycle does not see it, and a load in any later cycle of the group does.
- R8: grp_end empties the table at the clock edge. A store presented in the same cycle as grp_end is discarded. A load presented with grp_end is still checked against the group that is ending.
- R9: The table holds ENTRIES stores (4 by default). A store presented while the table is full is ignored and cannot cause a hazard.
- R10: Offset sums are formed with one extra bit and never wrap. A store at 0xFFFF of 8 bytes does not overlap a load at 0x0000.
- R11: When an offset operand lacks the constant flag, no range test is made. The load is then a hazard only through R1 or R2, even when the tag values are close or equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the table |
| grp_end | input | 1 | Pulse that closes the current dispatch group |
| st_valid | input | 1 | A store is issued this cycle |
| st_off_k | input | 1 | Store offset operand is a constant |
| st_off | input | 16 | Store offset operand tag or value |
| st_base_k | input | 1 | Store base operand constant flag |
| st_base | input | 16 | Store base operand tag |
| st_size | input | 2 | Store size code |
| ld_valid | input | 1 | A load is presented for checking |
| ld_off_k | input | 1 | Load offset operand is a constant |
| ld_off | input | 16 | Load offset operand tag or value |
| ld_base_k | input | 1 | Load base operand constant flag |
| ld_base | input | 16 | Load base operand tag |
| ld_size | input | 2 | Load size code |
| ld_hazard | output | 1 | The presented load overlaps a store of this group |

## Verification
The bench builds the block with its default of four table entries and 16-bit operands. At that depth a fifth store within one group is easy to produce, so the overflow rule gets exercised. The 16-bit width puts the top-of-range sums at 0xFFFF within a directed case. Random stimulus draws tags and offsets from a very small set of values. Exact, swapped, and range matches therefore occur often, and interleaved group ends keep the table moving between empty and full.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
  localparam int unsigned OFS_W = 16;
  localparam int unsigned SZ_W  = 2;

  typedef struct packed {
    logic             is_k;
    logic [OFS_W-1:0] val;
  } opnd_t;

  typedef struct packed {
    opnd_t            off;
    opnd_t            base;
    logic [SZ_W-1:0]  sz;
  } st_rec_t;

  // byte count from a size code: 1, 2, 4, 8
  function automatic logic [3:0] size_bytes(input logic [SZ_W-1:0] code);
    return 4'd1 << code;
  endfunction

  // constant-offset range test, sums one bit wider than the offsets
  function automatic logic ranges_hit(input logic [OFS_W-1:0] s_ofs,
                                      input logic [SZ_W-1:0]  s_sz,
                                      input logic [OFS_W-1:0] l_ofs,
                                      input logic [SZ_W-1:0]  l_sz);
    logic [OFS_W:0] s_end;
    logic [OFS_W:0] l_end;
    s_end = {1'b0, s_ofs} + {{(OFS_W-3){1'b0}}, size_bytes(s_sz)};
    l_end = {1'b0, l_ofs} + {{(OFS_W-3){1'b0}}, size_bytes(l_sz)};
    if (s_ofs < l_ofs) return s_end > {1'b0, l_ofs};
    else               return l_end > {1'b0, s_ofs};
  endfunction
endpackage

// File: rtl/sld_store_table.sv
`timescale 1ns/1ps
module sld_store_table #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  sld_pkg::st_rec_t       wr_rec,
  output sld_pkg::st_rec_t       recs [ENTRIES],
  output logic [ENTRIES-1:0]     vld,
  output logic [CNT_W-1:0]       cnt,
  output logic                   wr_take,
  output logic                   wr_drop
);
  logic full;

  assign full    = (cnt == CNT_W'(ENTRIES));
  assign wr_take = wr_en && !clr && !full;
  assign wr_drop = wr_en && !clr && full;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (wr_take) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_take && cnt == CNT_W'(i)) recs[i] <= wr_rec;
    end
    assign vld[i] = (cnt > CNT_W'(i));
  end
endmodule

// File: rtl/sld_entry_cmp.sv
`timescale 1ns/1ps
module sld_entry_cmp (
  input  logic                       vld,
  input  sld_pkg::st_rec_t           rec,
  input  sld_pkg::opnd_t             ld_off,
  input  sld_pkg::opnd_t             ld_base,
  input  logic [sld_pkg::SZ_W-1:0]   ld_size,
  output logic                       hit
);
  logic hit_exact;
  logic hit_swap;
  logic base_eq;
  logic both_k;
  logic hit_range;

  assign hit_exact = (ld_off == rec.off)  && (ld_base == rec.base);
  assign hit_swap  = (ld_off == rec.base) && (ld_base == rec.off);
  assign base_eq   = (ld_base == rec.base);
  assign both_k    = ld_off.is_k && rec.off.is_k;
  assign hit_range = base_eq && both_k &&
                     sld_pkg::ranges_hit(rec.off.val, rec.sz, ld_off.val, ld_size);
  assign hit       = vld && (hit_exact || hit_swap || hit_range);
endmodule

// File: rtl/st_ld_overlap_det.sv
`timescale 1ns/1ps
module st_ld_overlap_det #(
  parameter int unsigned ENTRIES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        grp_end,
  input  logic                        st_valid,
  input  logic                        st_off_k,
  input  logic [sld_pkg::OFS_W-1:0]   st_off,
  input  logic                        st_base_k,
  input  logic [sld_pkg::OFS_W-1:0]   st_base,
  input  logic [sld_pkg::SZ_W-1:0]    st_size,
  input  logic                        ld_valid,
  input  logic                        ld_off_k,
  input  logic [sld_pkg::OFS_W-1:0]   ld_off,
  input  logic                        ld_base_k,
  input  logic [sld_pkg::OFS_W-1:0]   ld_base,
  input  logic [sld_pkg::SZ_W-1:0]    ld_size,
  output logic                        ld_hazard
);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

  sld_pkg::st_rec_t  wr_rec;
  sld_pkg::st_rec_t  recs [ENTRIES];
  sld_pkg::opnd_t    l_off;
  sld_pkg::opnd_t    l_base;
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] ent_hit;
  logic [CNT_W-1:0]   ent_cnt;
  logic               rec_evt;
  logic               drop_evt;
  logic               any_hit;

  always_comb begin
    wr_rec.off.is_k  = st_off_k;
    wr_rec.off.val   = st_off;
    wr_rec.base.is_k = st_base_k;
    wr_rec.base.val  = st_base;
    wr_rec.sz        = st_size;
    l_off.is_k       = ld_off_k;
    l_off.val        = ld_off;
    l_base.is_k      = ld_base_k;
    l_base.val       = ld_base;
  end

  sld_store_table #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (grp_end),
    .wr_en   (st_valid),
    .wr_rec  (wr_rec),
    .recs    (recs),
    .vld     (vld),
    .cnt     (ent_cnt),
    .wr_take (rec_evt),
    .wr_drop (drop_evt)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    sld_entry_cmp u_cmp (
      .vld     (vld[i]),
      .rec     (recs[i]),
      .ld_off  (l_off),
      .ld_base (l_base),
      .ld_size (ld_size),
      .hit     (ent_hit[i])
    );
  end

  assign any_hit   = |ent_hit;
  assign ld_hazard = ld_valid && any_hit;
endmodule

// File: rtl/sld_chk.sv
`timescale 1ns/1ps
module sld_chk #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grp_end,
  input logic             ld_valid,
  input logic             ld_hazard,
  input logic [CNT_W-1:0] ent_cnt,
  input logic             rec_evt,
  input logic             drop_evt
);
  // R8
  clear_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> (ent_cnt == '0));

  // R6
  idle_no_haz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hazard);

  // R6
  empty_no_haz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_cnt == '0) |-> !ld_hazard);

  // R7
  record_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_evt |=> (ent_cnt == $past(ent_cnt) + 1'b1));

  // R9
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (ent_cnt == CNT_W'(ENTRIES)));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cnt <= CNT_W'(ENTRIES));
endmodule

bind st_ld_overlap_det sld_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_end   (grp_end),
  .ld_valid  (ld_valid),
  .ld_hazard (ld_hazard),
  .ent_cnt   (ent_cnt),
  .rec_evt   (rec_evt),
  .drop_evt  (drop_evt)
);

// File: tb/sim_st_ld_overlap_det.sv
`timescale 1ns/1ps
module sim_st_ld_overlap_det;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grp_end = 0, st_valid = 0, st_off_k = 0, st_base_k = 0;
  logic ld_valid = 0, ld_off_k = 0, ld_base_k = 0;
  logic [15:0] st_off = 0, st_base = 0, ld_off = 0, ld_base = 0;
  logic [1:0]  st_size = 0, ld_size = 0;
  logic ld_hazard;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the table
  int m_n = 0;
  bit m_ok[NE]; int m_o[NE]; bit m_bk[NE]; int m_b[NE]; int m_sz[NE];

  always #4 clk = ~clk;

  st_ld_overlap_det #(.ENTRIES(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .st_valid(st_valid),
    .st_off_k(st_off_k), .st_off(st_off), .st_base_k(st_base_k), .st_base(st_base),
    .st_size(st_size), .ld_valid(ld_valid), .ld_off_k(ld_off_k), .ld_off(ld_off),
    .ld_base_k(ld_base_k), .ld_base(ld_base), .ld_size(ld_size), .ld_hazard(ld_hazard)
  );

  // byte intervals [a, a+n) intersect when max start < min end
  function automatic bit model_haz();
    if (!ld_valid) return 0;
    for (int i = 0; i < m_n; i++) begin
      int s_end, l_end, lo, hi;
      if (ld_off_k == m_ok[i] && int'(ld_off) == m_o[i] &&
          ld_base_k == m_bk[i] && int'(ld_base) == m_b[i]) return 1;
      if (ld_off_k == m_bk[i] && int'(ld_off) == m_b[i] &&
          ld_base_k == m_ok[i] && int'(ld_base) == m_o[i]) return 1;
      if (ld_base_k == m_bk[i] && int'(ld_base) == m_b[i] && ld_off_k && m_ok[i]) begin
        s_end = m_o[i] + (1 << m_sz[i]);
        l_end = int'(ld_off) + (1 << ld_size);
        lo = (m_o[i] > int'(ld_off)) ? m_o[i] : int'(ld_off);
        hi = (s_end < l_end) ? s_end : l_end;
        if (lo < hi) return 1;
      end
    end
    return 0;
  endfunction

  task automatic set_st(bit ok, int o, bit bk, int b, int sz);
    st_valid = 1; st_off_k = ok; st_off = 16'(o); st_base_k = bk; st_base = 16'(b); st_size = 2'(sz);
  endtask

  task automatic set_ld(bit ok, int o, bit bk, int b, int sz);
    ld_valid = 1; ld_off_k = ok; ld_off = 16'(o); ld_base_k = bk; ld_base = 16'(b); ld_size = 2'(sz);
  endtask

  // check against the model, apply the clock edge to the model, move on
  task automatic tick(string req, bit use_exp, bit exp_val);
    bit e;
    #1;
    e = use_exp ? exp_val : model_haz();
    if (use_exp && e != model_haz()) $display("note: model differs from directed value in %s", req);
    checks++;
    if (ld_hazard !== e) begin
      errors++;
      $display("FAIL %s: ld_hazard=%0b expected %0b at %0t", req, ld_hazard, e, $time);
    end
    if (grp_end) m_n = 0;
    else if (st_valid && m_n < NE) begin
      m_ok[m_n] = st_off_k; m_o[m_n] = int'(st_off); m_bk[m_n] = st_base_k;
      m_b[m_n] = int'(st_base); m_sz[m_n] = int'(st_size); m_n++;
    end
    @(negedge clk);
    grp_end = 0; st_valid = 0; ld_valid = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6 empty after reset
    set_ld(1, 4, 0, 7, 2); tick("R6 reset empty", 1, 0);
    // R7 same-cycle store invisible, R1 visible next cycle
    set_st(1, 4, 0, 7, 2); set_ld(1, 4, 0, 7, 2); tick("R7 same cycle", 1, 0);
    set_ld(1, 4, 0, 7, 2); tick("R1 exact", 1, 1);
    // R2 swapped operands
    set_ld(0, 7, 1, 4, 2); tick("R2 swapped", 1, 1);
    // R6 no load
    ld_off_k = 1; ld_off = 4; ld_base = 7; tick("R6 ld_valid low", 1, 0);
    // store covers 4..7
    set_ld(1, 6, 0, 7, 1); tick("R3 store below, overlap", 1, 1);
    set_ld(1, 8, 0, 7, 0); tick("R3 store below, touching", 1, 0);
    set_ld(1, 2, 0, 7, 1); tick("R4 load below, touching", 1, 0);
    set_ld(1, 1, 0, 7, 2); tick("R4 load below, overlap", 1, 1);
    set_ld(1, 0, 0, 7, 3); tick("R5 8-byte code", 1, 1);
    set_ld(1, 0, 0, 7, 2); tick("R5 4-byte code", 1, 0);
    // R8 load with grp_end sees old group, then empty
    set_ld(1, 4, 0, 7, 2); grp_end = 1; tick("R8 load at group end", 1, 1);
    set_ld(1, 4, 0, 7, 2); tick("R8 cleared", 1, 0);
    // R8 store with grp_end discarded
    set_st(1, 4, 0, 7, 2); grp_end = 1; tick("R8 store at end", 1, 0);
    set_ld(1, 4, 0, 7, 2); tick("R8 store dropped", 1, 0);
    // R11 non-constant offsets
    set_st(0, 4, 0, 7, 3); tick("R11 setup", 1, 0);
    set_ld(0, 5, 0, 7, 0); tick("R11 tag offsets", 1, 0);
    set_ld(1, 4, 0, 7, 0); tick("R11 flag differs", 1, 0);
    grp_end = 1; tick("R11 end", 1, 0);
    // R9 overflow
    for (int i = 1; i <= 5; i++) begin set_st(1, 0, 0, i, 0); tick("R9 fill", 1, 0); end
    set_ld(1, 0, 0, 5, 0); tick("R9 fifth ignored", 1, 0);
    set_ld(1, 0, 0, 4, 0); tick("R9 fourth kept", 1, 1);
    grp_end = 1; tick("R9 end", 1, 0);
    // R10 no wrap
    set_st(1, 16'hFFFF, 0, 9, 3); tick("R10 setup", 1, 0);
    set_ld(1, 0, 0, 9, 0); tick("R10 no wrap", 1, 0);
    set_st(1, 16'hFFFE, 0, 9, 3); tick("R10 setup2", 1, 0);
    set_ld(1, 16'hFFFF, 0, 9, 0); tick("R10 top overlap", 1, 1);
    grp_end = 1; tick("R10 end", 1, 0);

    // random mix: R1 R2 R3 R4 R5 R9 R8
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 2) set_st($urandom % 2, $urandom % 12, $urandom % 2, $urandom % 3, $urandom % 4);
      if ($urandom % 4 != 0) set_ld($urandom % 2, $urandom % 12, $urandom % 2, $urandom % 3, $urandom % 4);
      grp_end = ($urandom % 6 == 0);
      tick("RND R1/R2/R3/R4 mix", 0, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule